// File: doc/BRIEF.md
# Mixed Edge/Level Interrupt Source Register

This block gathers three interrupt sources into one 6-bit status view and raises a single interrupt request line. Two sources are events: a rising edge on the external trigger input and a rising edge on the counter-1 output. Each of these is caught in a sticky latch. The third source is the DAC FIFO request, which is a level condition. Its status bit follows the input directly and is never stored.

Software sees one byte-wide location. A read strobe returns the status, and a write strobe loads the 8-bit enable mask. There is no separate acknowledge register. To acknowledge a latched edge, software writes its enable bit to zero and then writes it back to one. An edge arriving while its enable bit is zero is not recorded. The request line is high whenever a status bit is set and its enable bit is also set.

The sources are assumed to be synchronous to `clk`. The bus needs no handshake. A write strobe takes effect at the clock edge that samples it. Read data is valid combinationally during the cycle the read strobe is high and is zero at all other times. Neither strobe can be back-pressured.

Top module: `irq_mixed_src`

## Requirements
- R1: After reset the enable mask is 0x00, both edge latches are clear, `irq_o` is low, and a read with all sources low returns 0x00.
- R2: With enable bit 0 set, a rising edge on `trig_i` sets status bit 0. The bit stays set after `trig_i` falls and reads back as 1 on the next read.
- R3: With enable bit 5 set, a rising edge on `cnt1_i` sets status bit 5. The bit stays set after `cnt1_i` falls.
- R4: A rising edge on an edge-type source while its enable bit is 0 is not recorded. Setting the enable bit afterwards shows status 0 for that bit, and `irq_o` stays low.
- R5: Writing an enable bit to 0 clears the latch for that edge bit. Once the bit is re-enabled, the status bit reads 0.
- R6: Status bit 2 equals the live value of `fifo_req_i` whatever the enable mask holds.
- R7: `irq_o` is the OR, over all bits, of status AND enable. A set status bit whose enable bit is 0 does not raise `irq_o`.
- R8: Status bits 1, 3, 4, 6 and 7 always read as 0, even when every source is high and the mask is 0xFF.
- R9: Writing 0x00 to the mask drops `irq_o` in the cycle after the write and clears both edge latches one cycle later.
- R10: An edge source held high through an acknowledge is not latched again. It must go low and then rise before status sets again.
- R11: `rd_data_o` is 0x00 in every cycle where `rd_stb_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | External trigger source; a rising edge sets bit 0 |
| fifo_req_i | input | 1 | DAC FIFO request; a level that drives bit 2 |
| cnt1_i | input | 1 | Counter-1 output; a rising edge sets bit 5 |
| wr_stb_i | input | 1 | Write strobe; loads the enable mask |
| wr_data_i | input | 8 | Enable mask value |
| rd_stb_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Status byte while `rd_stb_i` is high, otherwise 0 |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is an acknowledge while the edge source is still high. The latch must clear and must not be set again by the same level. The stimulus raises `trig_i`, lets it latch, and then writes the mask without bit 0 and with bit 0 in consecutive cycles, keeping `trig_i` high throughout. A read confirms bit 0 is clear. The stimulus then drops `trig_i` and raises it again, and a second read confirms bit 0 sets on that fresh edge. A second hard case is an edge that arrives while its enable bit is clear: the bench pulses `cnt1_i` with bit 5 disabled and then enables it, to show the edge left no trace.

// File: rtl/irq_src_pkg.sv
package irq_src_pkg;

  localparam int STAT_W_DEF   = 6;
  localparam int BUS_W_DEF    = 8;
  localparam int TRIG_POS_DEF = 0;
  localparam int FIFO_POS_DEF = 2;
  localparam int CNT1_POS_DEF = 5;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_EDGE  = 2'd1,
    KIND_LEVEL = 2'd2
  } src_kind_e;

  function automatic src_kind_e kind_of(input int idx, input int trig_pos,
                                        input int fifo_pos, input int cnt1_pos);
    if (idx == trig_pos || idx == cnt1_pos) return KIND_EDGE;
    if (idx == fifo_pos) return KIND_LEVEL;
    return KIND_NONE;
  endfunction

endpackage

// File: rtl/irq_edge_cell.sv
module irq_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic src_i,
  input  logic en_i,
  output logic stat_o
);
  logic prev_q;
  logic latch_q;
  logic rise;

  assign rise = src_i & ~prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= src_i;
      latch_q <= en_i & (latch_q | rise);
    end
  end

  assign stat_o = latch_q;

  // R4: a latch can only be set when its enable was on and the source high
  assert_rise_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(en_i && src_i));

  // R5: a disabled latch clears on the next edge
  assert_disable_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && latch_q) |=> !latch_q);

  // R2: an enabled latch is sticky
  assert_sticky_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && latch_q) |=> latch_q);

endmodule

// File: rtl/irq_level_cell.sv
module irq_level_cell (
  input  logic src_i,
  output logic stat_o
);
  assign stat_o = src_i;
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_stb_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] en_o
);
  logic [W-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        en_q <= '0;
    else if (wr_stb_i) en_q <= wr_data_i;
  end

  assign en_o = en_q;

  // R1: the mask only moves on a write strobe
  assert_mask_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb_i |=> $stable(en_q));

endmodule

// File: rtl/irq_mixed_src.sv
module irq_mixed_src
  import irq_src_pkg::*;
#(
  parameter int STAT_W   = STAT_W_DEF,
  parameter int BUS_W    = BUS_W_DEF,
  parameter int TRIG_POS = TRIG_POS_DEF,
  parameter int FIFO_POS = FIFO_POS_DEF,
  parameter int CNT1_POS = CNT1_POS_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             fifo_req_i,
  input  logic             cnt1_i,
  input  logic             wr_stb_i,
  input  logic [BUS_W-1:0] wr_data_i,
  input  logic             rd_stb_i,
  output logic [BUS_W-1:0] rd_data_o,
  output logic             irq_o
);
  localparam int PAD_W = BUS_W - STAT_W;
  localparam logic [BUS_W-1:0] USED_SET =
    (BUS_W'(1) << TRIG_POS) | (BUS_W'(1) << FIFO_POS) | (BUS_W'(1) << CNT1_POS);

  logic [STAT_W-1:0] src_vec;
  logic [STAT_W-1:0] status;
  logic [BUS_W-1:0]  status_full;
  logic [BUS_W-1:0]  en_q;

  always_comb begin
    src_vec           = '0;
    src_vec[TRIG_POS] = trig_i;
    src_vec[FIFO_POS] = fifo_req_i;
    src_vec[CNT1_POS] = cnt1_i;
  end

  irq_enable_reg #(.W(BUS_W)) u_mask (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb_i  (wr_stb_i),
    .wr_data_i (wr_data_i),
    .en_o      (en_q)
  );

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (kind_of(i, TRIG_POS, FIFO_POS, CNT1_POS) == KIND_EDGE) begin : g_edge
      irq_edge_cell u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_vec[i]),
        .en_i   (en_q[i]),
        .stat_o (status[i])
      );
    end else begin : g_level
      irq_level_cell u_cell (
        .src_i  (src_vec[i]),
        .stat_o (status[i])
      );
    end
  end

  assign status_full = {{PAD_W{1'b0}}, status};
  assign irq_o       = |(status_full & en_q);
  assign rd_data_o   = rd_stb_i ? status_full : '0;

  // R9: an all-zero mask write silences the request line
  assert_zero_mask_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && wr_data_i == '0) |=> !irq_o);

  // R8: unused positions never read as one
  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_o & ~USED_SET) == '0);

  // R7: a request needs some enable bit
  assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (en_q != '0));

endmodule

// File: tb/irq_mixed_src_test.sv
module irq_mixed_src_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig_i = 1'b0, fifo_req_i = 1'b0, cnt1_i = 1'b0;
  logic       wr_stb_i = 1'b0, rd_stb_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic [7:0] rd_data_o;
  logic       irq_o;

  int total = 0;
  int bad   = 0;

  typedef struct { logic [7:0] val; string tag; } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mixed_src uut (
    .clk(clk), .rst_n(rst_n), .trig_i(trig_i), .fifo_req_i(fifo_req_i),
    .cnt1_i(cnt1_i), .wr_stb_i(wr_stb_i), .wr_data_i(wr_data_i),
    .rd_stb_i(rd_stb_i), .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  // monitor: pops one expected read per strobed cycle
  always @(negedge clk) begin
    if (rd_stb_i && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      total++;
      if (rd_data_o !== e.val) begin
        bad++;
        $display("FAIL %s: rd_data actual=%02h expected=%02h", e.tag, rd_data_o, e.val);
      end
      if ((rd_data_o & 8'hDA) !== 8'h00) begin
        bad++; total++;
        $display("FAIL R8: unused bits actual=%02h expected=00", rd_data_o & 8'hDA);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_mask(input logic [7:0] v);
    wr_stb_i = 1'b1; wr_data_i = v;
    step();
    wr_stb_i = 1'b0; wr_data_i = 8'h00;
  endtask

  task automatic rd_expect(input logic [7:0] v, input string tag);
    exp_t e;
    e.val = v; e.tag = tag;
    sb_q.push_back(e);
    rd_stb_i = 1'b1;
    step();
    rd_stb_i = 1'b0;
  endtask

  task automatic chk_irq(input logic v, input string tag);
    @(negedge clk);
    total++;
    if (irq_o !== v) begin
      bad++;
      $display("FAIL %s: irq actual=%0b expected=%0b", tag, irq_o, v);
    end
    @(posedge clk); #1;
  endtask

  task automatic chk_rd_idle(input string tag);
    @(negedge clk);
    total++;
    if (rd_data_o !== 8'h00) begin
      bad++;
      $display("FAIL %s: idle rd_data actual=%02h expected=00", tag, rd_data_o);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk_irq(1'b0, "R1");
    rd_expect(8'h00, "R1");

    // level source, masked then unmasked
    fifo_req_i = 1'b1; step();
    rd_expect(8'h04, "R6");
    chk_irq(1'b0, "R7");
    wr_mask(8'h04);
    chk_irq(1'b1, "R7");
    fifo_req_i = 1'b0; step();
    chk_irq(1'b0, "R6");
    rd_expect(8'h00, "R6");

    // edge on trigger, sticky
    wr_mask(8'h01);
    trig_i = 1'b1; step();
    trig_i = 1'b0; step();
    rd_expect(8'h01, "R2");
    chk_irq(1'b1, "R2");

    // acknowledge by disable / re-enable
    wr_mask(8'h00);
    chk_irq(1'b0, "R9");
    wr_mask(8'h01);
    rd_expect(8'h00, "R5");
    chk_irq(1'b0, "R5");

    // counter edge while disabled is lost
    cnt1_i = 1'b1; step();
    cnt1_i = 1'b0; step();
    rd_expect(8'h00, "R4");
    wr_mask(8'h21);
    rd_expect(8'h00, "R4");
    chk_irq(1'b0, "R4");

    // counter edge while enabled
    cnt1_i = 1'b1; step();
    cnt1_i = 1'b0; step();
    rd_expect(8'h20, "R3");
    chk_irq(1'b1, "R3");

    // held-high source across acknowledge
    trig_i = 1'b1; step();
    rd_expect(8'h21, "R10");
    wr_mask(8'h20);
    wr_mask(8'h21);
    step();
    rd_expect(8'h20, "R10");
    trig_i = 1'b0; step();
    trig_i = 1'b1; step();
    rd_expect(8'h21, "R10");

    // everything high, full mask
    fifo_req_i = 1'b1;
    wr_mask(8'hFF);
    rd_expect(8'h25, "R8");
    chk_rd_idle("R11");

    // zero mask silences and clears latches
    wr_mask(8'h00);
    chk_irq(1'b0, "R9");
    rd_expect(8'h04, "R9");

    // enable mask without level bit, only level active
    wr_mask(8'hFB);
    chk_irq(1'b0, "R7");
    wr_mask(8'h04);
    chk_irq(1'b1, "R7");

    step();
    if (sb_q.size() != 0) begin
      bad++; total++;
      $display("FAIL R1: scoreboard left actual=%0d expected=0", sb_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    bad++; total++;
    $display("FAIL R1: watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule